// File: doc/BRIEF.md
# Shadow-Tag Coherence Directory Bank

This block sits next to one bank of a shared second-level cache. It holds an exact copy of the tags of every first-level data cache, restricted to the lines that map to this bank. First-level lines are either valid or invalid. Those caches write through, allocate on loads and never allocate on stores. The directory therefore sees every allocation, because each allocation is a load miss, and every write, because each write is a store.

A load miss carries the requesting cache id and the way that cache will evict. The directory writes the missing line's tag into exactly that (cache, set, way) slot and overwrites whatever was there. A store compares all caches and ways of the indexed set in one cycle. It clears every matching valid slot and, in the same cycle, pushes one invalidation per holding cache into an in-order queue, lowest cache id first. This includes the cache that issued the store. Each invalidation carries cache id, full first-level set index and way. A store is refused while the queue lacks room for a worst-case fan-out of one message per cache. Load misses are always accepted.

Top module: `shdir_bank`

## Requirements
- R1: After reset every directory slot is invalid, the queue is empty (`inv_valid` low) and a store request sees `req_ready` high and produces no invalidation.
- R2: An accepted load miss writes the line tag into slot (`req_cache`, set, `req_way`) and replaces the previous occupant. A later store to the replaced line yields no invalidation, and a store to the new line yields one with that way.
- R3: An accepted store produces one invalidation for every cache holding a valid matching slot, including the storing cache itself. The value of `req_cache` on a store has no effect.
- R4: The invalidations of one store enter the queue in ascending cache-id order. Each carries `inv_cache`, `inv_set` equal to address bits [10:4] of the store, and `inv_way` equal to the way holding the line.
- R5: Each slot whose invalidation is queued is cleared in the same cycle, so a repeated store to the same line yields nothing.
- R6: Invalidations leave in the order they were queued, one per cycle with `inv_valid` and `inv_ready` both high. While `inv_ready` is low the presented message and `inv_valid` stay unchanged.
- R7: With `req_is_store` high, `req_ready` is low whenever the free queue slots are fewer than the number of caches. A refused store changes nothing, the queue never overflows, and loads are accepted regardless.
- R8: Matching is per 16-byte line. A store to another byte of a held line matches it. A different tag in the same set does not match, and neither does the same tag in another set.
- R9: Every request address carries this bank's number in address bits [7:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_is_store | input | 1 | 1 = store lookup, 0 = load-miss record |
| req_cache | input | 3 | Requesting first-level cache id |
| req_way | input | 2 | Way the requesting cache will replace (loads) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | Request accepted this cycle when high |
| inv_valid | output | 1 | Invalidation message present |
| inv_ready | input | 1 | Consumer takes the message |
| inv_cache | output | 3 | Target cache id |
| inv_set | output | 7 | First-level set index |
| inv_way | output | 2 | Way to invalidate |

## Verification
Assertions check on every cycle that the queue never exceeds its depth, that a refused store leaves the queue occupancy unchanged or lower, that an accepted store's fan-out fits the free slots, that a held message stays stable, and that requests carry this bank's select bits. Only the bench scenarios can show the content of the directory: that a load fills exactly the reported slot and evicts its predecessor, that stores find every holder in ascending cache order, that cleared slots stay cleared, that line granularity holds, and that a refused store leaves its sharers in place. A bench model of the directory and of the message queue is compared against every delivered message, over directed sweeps across all eight caches and a long pseudo-random mix under random backpressure.

// File: rtl/shdir_pkg.sv
package shdir_pkg;
  // Index of the least significant set bit; 0 when none set.
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/shdir_tag_array.sv
module shdir_tag_array #(
  parameter int NC     = 8,
  parameter int NW     = 4,
  parameter int NS     = 32,
  parameter int TAG_W  = 29,
  localparam int CID_W = $clog2(NC),
  localparam int WAY_W = $clog2(NW),
  localparam int SET_W = $clog2(NS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [CID_W-1:0]                 wr_cache,
  input  logic [WAY_W-1:0]                 wr_way,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [SET_W-1:0]                 acc_set,
  input  logic [NC-1:0]                    clr_en,
  input  logic [NC-1:0][WAY_W-1:0]         clr_way,
  output logic [NC-1:0][NW-1:0]            rd_valid,
  output logic [NC-1:0][NW-1:0][TAG_W-1:0] rd_tag
);
  logic [NS-1:0][NC-1:0][NW-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]              tag_q [NS][NC][NW];

  always_comb begin
    vld_d = vld_q;
    for (int c = 0; c < NC; c++) begin
      if (clr_en[c]) vld_d[acc_set][c][clr_way[c]] = 1'b0;
    end
    if (wr_en) vld_d[acc_set][wr_cache][wr_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[acc_set][wr_cache][wr_way] <= wr_tag;
  end

  for (genvar c = 0; c < NC; c++) begin : g_rd_c
    for (genvar w = 0; w < NW; w++) begin : g_rd_w
      assign rd_valid[c][w] = vld_q[acc_set][c][w];
      assign rd_tag[c][w]   = tag_q[acc_set][c][w];
    end
  end
endmodule

// File: rtl/shdir_match.sv
module shdir_match #(
  parameter int NC     = 8,
  parameter int NW     = 4,
  parameter int TAG_W  = 29,
  localparam int WAY_W = $clog2(NW),
  localparam int OFS_W = $clog2(NC + 1)
) (
  input  logic [NC-1:0][NW-1:0]            rd_valid,
  input  logic [NC-1:0][NW-1:0][TAG_W-1:0] rd_tag,
  input  logic [TAG_W-1:0]                 lk_tag,
  output logic [NC-1:0]                    hit,
  output logic [NC-1:0][WAY_W-1:0]         hit_way,
  output logic [NC-1:0][OFS_W-1:0]         hit_ofs,
  output logic [OFS_W-1:0]                 hit_cnt
);
  import shdir_pkg::*;

  for (genvar c = 0; c < NC; c++) begin : g_cache
    logic [NW-1:0] way_hit;
    for (genvar w = 0; w < NW; w++) begin : g_way
      assign way_hit[w] = rd_valid[c][w] && (rd_tag[c][w] == lk_tag);
    end
    assign hit[c]     = |way_hit;
    assign hit_way[c] = WAY_W'(lowest_set(32'(way_hit)));
  end

  // Prefix count gives each holder its queue slot, lowest cache id first.
  always_comb begin
    logic [OFS_W-1:0] run;
    run = '0;
    for (int c = 0; c < NC; c++) begin
      hit_ofs[c] = run;
      run        = run + OFS_W'(hit[c]);
    end
    hit_cnt = run;
  end
endmodule

// File: rtl/shdir_inv_queue.sv
module shdir_inv_queue #(
  parameter int DEPTH  = 16,
  parameter int EW     = 12,
  parameter int NPUSH  = 8,
  localparam int OFS_W = $clog2(NPUSH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPUSH-1:0]            push_vec,
  input  logic [NPUSH-1:0][OFS_W-1:0] push_ofs,
  input  logic [NPUSH-1:0][EW-1:0]    push_data,
  input  logic [OFS_W-1:0]            push_n,
  input  logic                        pop,
  output logic                        out_valid,
  output logic [EW-1:0]               out_data,
  output logic [CNT_W-1:0]            count
);
  logic [PTR_W-1:0]            rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0]            cnt_q, cnt_d;
  logic [DEPTH-1:0][EW-1:0]    mem_q;
  logic [DEPTH-1:0]            slot_we;
  logic [DEPTH-1:0][EW-1:0]    slot_wd;

  always_comb begin
    slot_we = '0;
    slot_wd = '0;
    for (int j = 0; j < NPUSH; j++) begin
      if (push_vec[j]) begin
        slot_we[PTR_W'(wr_q + PTR_W'(push_ofs[j]))] = 1'b1;
        slot_wd[PTR_W'(wr_q + PTR_W'(push_ofs[j]))] = push_data[j];
      end
    end
    wr_d  = wr_q + PTR_W'(push_n);
    rd_d  = rd_q + PTR_W'(pop);
    cnt_d = cnt_q + CNT_W'(push_n) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem_q[i] <= slot_wd[i];
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_q];
  assign count     = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R7
endmodule

// File: rtl/shdir_bank.sv
module shdir_bank #(
  parameter int NUM_CACHES  = 8,
  parameter int NUM_WAYS    = 4,
  parameter int LINE_BYTES  = 16,
  parameter int L1_SETS     = 128,
  parameter int NUM_BANKS   = 4,
  parameter int BANK_BYTES  = 64,
  parameter int BANK_ID     = 0,
  parameter int ADDR_W      = 40,
  parameter int QUEUE_DEPTH = 16,
  localparam int CID_W      = $clog2(NUM_CACHES),
  localparam int WAY_W      = $clog2(NUM_WAYS),
  localparam int SET_W      = $clog2(L1_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_store,
  input  logic [CID_W-1:0]  req_cache,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [CID_W-1:0]  inv_cache,
  output logic [SET_W-1:0]  inv_set,
  output logic [WAY_W-1:0]  inv_way
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int BANK_W   = $clog2(NUM_BANKS);
  localparam int SB       = $clog2(BANK_BYTES) - LINE_LSB;
  localparam int LSET_W   = SET_W - BANK_W;
  localparam int NLS      = L1_SETS / NUM_BANKS;
  localparam int TAG_W    = ADDR_W - LINE_LSB - SET_W;
  localparam int OFS_W    = $clog2(NUM_CACHES + 1);
  localparam int EW       = CID_W + SET_W + WAY_W;
  localparam int CNT_W    = $clog2(QUEUE_DEPTH + 1);

  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [LSET_W-1:0] loc_set;
  logic [BANK_W-1:0] lk_bank;
  logic              acc, ld_wr, st_acc;
  logic [CNT_W-1:0]  q_count, q_free;

  assign lk_set  = req_addr[LINE_LSB +: SET_W];
  assign lk_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign lk_bank = lk_set[SB +: BANK_W];
  assign loc_set = {lk_set[SET_W-1:SB+BANK_W], lk_set[SB-1:0]};

  assign q_free    = CNT_W'(QUEUE_DEPTH) - q_count;
  assign req_ready = !req_is_store || (q_free >= CNT_W'(NUM_CACHES));
  assign acc       = req_valid && req_ready;
  assign ld_wr     = acc && !req_is_store;
  assign st_acc    = acc && req_is_store;

  logic [NUM_CACHES-1:0][NUM_WAYS-1:0]            rd_valid;
  logic [NUM_CACHES-1:0][NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [NUM_CACHES-1:0]                          hit, clr_en;
  logic [NUM_CACHES-1:0][WAY_W-1:0]               hit_way;
  logic [NUM_CACHES-1:0][OFS_W-1:0]               hit_ofs;
  logic [OFS_W-1:0]                               hit_cnt, push_n;
  logic [NUM_CACHES-1:0][EW-1:0]                  push_data;
  logic [EW-1:0]                                  q_out;

  assign clr_en = hit & {NUM_CACHES{st_acc}};
  assign push_n = st_acc ? hit_cnt : '0;

  for (genvar c = 0; c < NUM_CACHES; c++) begin : g_push
    assign push_data[c] = {CID_W'(c), lk_set, hit_way[c]};
  end

  shdir_tag_array #(
    .NC(NUM_CACHES), .NW(NUM_WAYS), .NS(NLS), .TAG_W(TAG_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ld_wr),
    .wr_cache (req_cache),
    .wr_way   (req_way),
    .wr_tag   (lk_tag),
    .acc_set  (loc_set),
    .clr_en   (clr_en),
    .clr_way  (hit_way),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag)
  );

  shdir_match #(
    .NC(NUM_CACHES), .NW(NUM_WAYS), .TAG_W(TAG_W)
  ) u_match (
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .lk_tag   (lk_tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .hit_ofs  (hit_ofs),
    .hit_cnt  (hit_cnt)
  );

  shdir_inv_queue #(
    .DEPTH(QUEUE_DEPTH), .EW(EW), .NPUSH(NUM_CACHES)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_vec  (clr_en),
    .push_ofs  (hit_ofs),
    .push_data (push_data),
    .push_n    (push_n),
    .pop       (inv_valid && inv_ready),
    .out_valid (inv_valid),
    .out_data  (q_out),
    .count     (q_count)
  );

  assign {inv_cache, inv_set, inv_way} = q_out;

  AST_BANK_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (lk_bank == BANK_W'(BANK_ID))); // R9
  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable({inv_cache, inv_set, inv_way}))); // R6
  AST_REFUSED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_store && !req_ready) |=> (q_count <= $past(q_count))); // R7
  AST_FANOUT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    st_acc |-> (CNT_W'(hit_cnt) <= q_free)); // R7
endmodule

// File: tb/shdir_bank_bench.sv
module shdir_bank_bench;
  localparam int CLK_P = 10;
  localparam int NC = 8, NW = 4, AW = 16, BID = 1, NLS = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_store = 1'b0, inv_ready = 1'b0;
  logic [2:0] req_cache = '0;
  logic [1:0] req_way = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, inv_valid;
  logic [2:0] inv_cache;
  logic [6:0] inv_set;
  logic [1:0] inv_way;

  shdir_bank #(.BANK_ID(BID), .ADDR_W(AW)) u_shdir_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_cache(req_cache), .req_way(req_way), .req_addr(req_addr), .req_ready(req_ready),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_cache(inv_cache),
    .inv_set(inv_set), .inv_way(inv_way));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, pops = 0;
  bit m_v [NC][NLS][NW];
  int m_t [NC][NLS][NW];
  int eq_c [1024], eq_s [1024], eq_w [1024];
  int qh = 0, qt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int lset, input int off);
    logic [6:0] s;
    s = {3'(lset >> 2), 2'(BID), 2'(lset)};
    return {5'(tag), s, 4'(off)};
  endfunction

  // Monitor and reference model, sampled just before each rising edge.
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst_n) begin
      if (inv_valid && inv_ready) begin
        pops++;
        if (qh == qt) chk(1'b0, "R3 R6 unexpected message cache", int'(inv_cache), -1);
        else begin
          chk(int'(inv_cache) == eq_c[qh % 1024], "R4 R6 cache id", int'(inv_cache), eq_c[qh % 1024]);
          chk(int'(inv_set) == eq_s[qh % 1024], "R4 set index", int'(inv_set), eq_s[qh % 1024]);
          chk(int'(inv_way) == eq_w[qh % 1024], "R4 way", int'(inv_way), eq_w[qh % 1024]);
          qh++;
        end
      end
      if (req_valid && req_ready) begin
        int tg, ls, s7;
        tg = int'(req_addr[15:11]);
        s7 = int'(req_addr[10:4]);
        ls = ((s7 >> 4) << 2) | (s7 & 3);
        if (!req_is_store) begin
          m_v[req_cache][ls][req_way] = 1'b1;
          m_t[req_cache][ls][req_way] = tg;
        end else begin
          for (int c = 0; c < NC; c++) begin
            for (int w = 0; w < NW; w++) begin
              if (m_v[c][ls][w] && m_t[c][ls][w] == tg) begin
                m_v[c][ls][w] = 1'b0;
                eq_c[qt % 1024] = c; eq_s[qt % 1024] = s7; eq_w[qt % 1024] = w;
                qt++;
                break;
              end
            end
          end
        end
      end
    end
  end

  task automatic issue(input bit st, input int c, input int w, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_is_store = st; req_cache = 3'(c); req_way = 2'(w); req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); req_valid = 1'b0; end
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 1'b0; inv_ready = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #2;
      if (qh == qt && !inv_valid) break;
    end
    chk(qh == qt, "R6 all queued messages delivered", qt - qh, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    logic [15:0] r;
    logic [5:0] hold;
    foreach (m_v[c, s, w]) m_v[c][s][w] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req_is_store = 1'b1;
    #1;
    chk(inv_valid == 1'b0, "R1 queue empty after reset", int'(inv_valid), 0);
    chk(req_ready == 1'b1, "R1 store ready after reset", int'(req_ready), 1);
    inv_ready = 1'b1;
    p0 = pops;
    for (int s = 0; s < NLS; s += 7) issue(1'b1, 0, 0, mk(3, s, 0));
    idle(3);
    chk(pops == p0 && !inv_valid, "R1 no message from empty directory", pops - p0, 0);

    // All caches share one line, each in way c%4; store from cache 3.
    for (int c = NC - 1; c >= 0; c--) issue(1'b0, c, c % 4, mk(9, 5, 0));
    issue(1'b1, 3, 0, mk(9, 5, 12));
    p0 = pops;
    drain();
    chk(pops - p0 == NC, "R3 every holder invalidated", pops - p0, NC);
    p0 = pops;
    issue(1'b1, 3, 0, mk(9, 5, 0));
    drain();
    chk(pops == p0, "R5 cleared entries stay cleared", pops - p0, 0);

    // Replacement of a slot.
    issue(1'b0, 2, 1, mk(4, 17, 0));
    issue(1'b0, 2, 1, mk(6, 17, 0));
    p0 = pops;
    issue(1'b1, 0, 0, mk(4, 17, 0));
    drain();
    chk(pops == p0, "R2 replaced line not invalidated", pops - p0, 0);
    issue(1'b1, 7, 0, mk(6, 17, 0));
    drain();
    chk(pops - p0 == 1, "R2 new occupant invalidated", pops - p0, 1);

    // Line granularity.
    issue(1'b0, 5, 0, mk(11, 8, 0));
    issue(1'b0, 5, 1, mk(11, 9, 0));
    p0 = pops;
    issue(1'b1, 1, 0, mk(12, 8, 3));
    drain();
    chk(pops == p0, "R8 other tag in same set not matched", pops - p0, 0);
    issue(1'b1, 1, 0, mk(11, 8, 15));
    drain();
    chk(pops - p0 == 1, "R8 other byte of line matched, other set kept", pops - p0, 1);
    issue(1'b1, 1, 0, mk(11, 9, 0));
    drain();
    chk(pops - p0 == 2, "R8 same tag other set still held", pops - p0, 2);

    // Backpressure and store refusal.
    inv_ready = 1'b0;
    for (int c = 0; c < NC; c++) issue(1'b0, c, 3 - (c % 4), mk(20, 30, 0));
    for (int c = 0; c < NC; c++) issue(1'b0, c, c % 4, mk(21, 31, 0));
    issue(1'b1, 0, 0, mk(20, 30, 0));
    issue(1'b1, 0, 0, mk(21, 31, 0));
    @(negedge clk);
    req_valid = 1'b0; req_is_store = 1'b1; #1;
    chk(req_ready == 1'b0, "R7 store refused when queue full", int'(req_ready), 0);
    req_is_store = 1'b0; #1;
    chk(req_ready == 1'b1, "R7 load accepted when queue full", int'(req_ready), 1);
    for (int c = 0; c < NC; c++) issue(1'b0, c, 2, mk(22, 1, 0));
    @(negedge clk);
    req_valid = 1'b1; req_is_store = 1'b1; req_addr = mk(22, 1, 0); #1;
    chk(req_ready == 1'b0, "R7 store held off", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0; #1;
    hold = {inv_cache, inv_set[1:0], inv_way[0]};
    chk(inv_valid && int'(inv_cache) == eq_c[qh % 1024], "R6 head presented", int'(inv_cache), eq_c[qh % 1024]);
    repeat (3) @(negedge clk);
    #1;
    chk(inv_valid && {inv_cache, inv_set[1:0], inv_way[0]} == hold, "R6 head stable while stalled", int'({inv_cache, inv_set[1:0], inv_way[0]}), int'(hold));
    p0 = pops;
    drain();
    chk(pops - p0 == 2 * NC, "R6 both stores delivered in order", pops - p0, 2 * NC);
    p0 = pops;
    issue(1'b1, 4, 0, mk(22, 1, 0));
    drain();
    chk(pops - p0 == NC, "R7 refused store left sharers in place", pops - p0, NC);

    // Pseudo-random mix under random backpressure.
    r = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      bit st, held;
      int c, w, tg, ls;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      st = r[0] & r[1];
      c = int'(r[4:2]); w = int'(r[6:5]); tg = int'(r[8:7]); ls = int'(r[9]) * 13;
      inv_ready = r[15] | r[14];
      held = 1'b0;
      for (int x = 0; x < NW; x++) if (m_v[c][ls][x] && m_t[c][ls][x] == tg) held = 1'b1;
      if (st) issue(1'b1, c, 0, mk(tg, ls, int'(r[13:10])));
      else if (!held) issue(1'b0, c, w, mk(tg, ls, 0));
      else idle(1);
    end
    drain();
    chk(!inv_valid, "R6 queue empty at end", int'(inv_valid), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule